// File: doc/BRIEF.md
# Serial Status Snapshot Shifter

This block lets a host controller read a status snapshot over a three-wire serial link. It combines two input-port levels, a 20-bit counter result and four sticky unlock flags into a 28-bit word. It then returns that word one bit at a time on a single data-out line.

The block samples the host link signals (serial clock, enable, read-mode select) and the status inputs on its own system clock, and all of them are taken as synchronous to it. When enable and read-mode are both high and were not both high in the previous system cycle, the word is captured once. The block does not track its inputs continuously. On the same capture it sends a one-cycle clear pulse to the unlock detector, so that the detector's sticky flags restart. After capture, each falling edge of the serial clock moves the next bit onto the data-out line, and the host samples it on the rising edge.

Top module: `status_shift_out`

## Requirements
- R1: After reset, `sdo_o` and `unlock_clr_o` are 0.
- R2: The word is captured in the system cycle where `sen_i & rd_mode_i` goes from 0 to 1. Changes on `port_i`, `count_i` or `unlock_i` after that cycle do not alter the bits shifted out in that session.
- R3: The bit order, counted from the first bit shifted, is as follows. Bit 0 is `port_i[0]` and bit 1 is `port_i[1]`. Bits 2..21 are `count_i[19]` down to `count_i[0]`. Bits 22..25 are `unlock_i[3]` down to `unlock_i[0]`. Bits 26 and 27 are 0.
- R4: `sdo_o` shows bit 0 from the first system cycle after capture. It advances by one bit only in the system cycle after the serial clock is seen falling, and it is stable at every other time during a session.
- R5: Whenever `sen_i` or `rd_mode_i` is low, `sdo_o` is 0 from the next system cycle on, and serial clock edges have no effect.
- R6: `unlock_clr_o` is high for exactly one system cycle, the cycle right after capture, and is low at all other times.
- R7: Once all 28 bits have been shifted, further falling edges place 0 on `sdo_o`.
- R8: Each new session, started by leaving and then re-entering read mode, captures fresh input values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sclk_i | input | 1 | Host serial clock, sampled on clk_i |
| sen_i | input | 1 | Host serial enable, high active |
| rd_mode_i | input | 1 | High selects read-out mode |
| port_i | input | 2 | Input-port levels |
| count_i | input | 20 | Counter result |
| unlock_i | input | 4 | Sticky unlock flags |
| sdo_o | output | 1 | Serial data out |
| unlock_clr_o | output | 1 | One-cycle clear pulse to the unlock detector |

## Verification
The bench runs read sessions with random port, counter and flag values. It also runs directed words of all ones, of alternating bits and of all zeros, because these expose bit-order mistakes, off-by-one shifts and stuck bits. Some sessions scramble the inputs right after capture, which shows whether the block keeps a snapshot or tracks its inputs live. Other sessions toggle the serial clock with enable or read-mode low, or keep shifting past the last bit, to confirm the idle-low and zero-fill behaviour.

// File: rtl/sso_pkg.sv
package sso_pkg;
    localparam int DEF_PORT_W = 2;
    localparam int DEF_CNT_W  = 20;
    localparam int DEF_UL_W   = 4;
    localparam int DEF_PAD_W  = 2;

    typedef enum logic [1:0] {
        SSO_IDLE  = 2'd0,
        SSO_LOAD  = 2'd1,
        SSO_SHIFT = 2'd2,
        SSO_HOLD  = 2'd3
    } sso_op_e;
endpackage

// File: rtl/sso_edge.sv
module sso_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sclk_i,
    output logic fall_o
);
    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sclk_i;
        fall_o    = st_q.prev & ~sclk_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/sso_frame.sv
module sso_frame #(
    parameter int PORT_W = 2,
    parameter int CNT_W  = 20,
    parameter int UL_W   = 4,
    parameter int PAD_W  = 2,
    localparam int FRAME_W = PORT_W + CNT_W + UL_W + PAD_W
) (
    input  logic [PORT_W-1:0]  port_i,
    input  logic [CNT_W-1:0]   count_i,
    input  logic [UL_W-1:0]    unlock_i,
    output logic [FRAME_W-1:0] frame_o
);
    localparam int CNT_TOP = FRAME_W - 1 - PORT_W;
    localparam int UL_TOP  = CNT_TOP - CNT_W;

    // port bit 0 goes out first, so it sits at the MSB
    for (genvar g = 0; g < PORT_W; g++) begin : g_port
        assign frame_o[FRAME_W-1-g] = port_i[g];
    end

    assign frame_o[CNT_TOP -: CNT_W] = count_i;
    assign frame_o[UL_TOP -: UL_W]   = unlock_i;
    assign frame_o[PAD_W-1:0]        = '0;
endmodule

// File: rtl/sso_shifter.sv
module sso_shifter
    import sso_pkg::*;
#(
    parameter int FRAME_W = 28
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               sel_i,
    input  logic               fall_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic               sdo_o,
    output logic               clr_o
);
    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic               dout;
        logic               clr;
        logic               sel;
    } shift_st_t;

    shift_st_t st_d, st_q;
    sso_op_e   op;

    always_comb begin
        if (!sel_i)              op = SSO_IDLE;
        else if (!st_q.sel)      op = SSO_LOAD;
        else if (fall_i)         op = SSO_SHIFT;
        else                     op = SSO_HOLD;

        st_d     = st_q;
        st_d.sel = sel_i;
        st_d.clr = (op == SSO_LOAD);
        unique case (op)
            SSO_IDLE: st_d.dout = 1'b0;
            SSO_LOAD: begin
                st_d.sr   = frame_i;
                st_d.dout = frame_i[FRAME_W-1];
            end
            SSO_SHIFT: begin
                st_d.sr   = {st_q.sr[FRAME_W-2:0], 1'b0};
                st_d.dout = st_q.sr[FRAME_W-2];
            end
            default: st_d.dout = st_q.dout;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sdo_o = st_q.dout;
    assign clr_o = st_q.clr;
endmodule

// File: rtl/status_shift_out.sv
module status_shift_out
    import sso_pkg::*;
#(
    parameter int PORT_W = DEF_PORT_W,
    parameter int CNT_W  = DEF_CNT_W,
    parameter int UL_W   = DEF_UL_W,
    parameter int PAD_W  = DEF_PAD_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sclk_i,
    input  logic              sen_i,
    input  logic              rd_mode_i,
    input  logic [PORT_W-1:0] port_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [UL_W-1:0]   unlock_i,
    output logic              sdo_o,
    output logic              unlock_clr_o
);
    localparam int FRAME_W = PORT_W + CNT_W + UL_W + PAD_W;

    logic               fall;
    logic               sel;
    logic [FRAME_W-1:0] frame;

    assign sel = sen_i & rd_mode_i;

    sso_edge u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sclk_i (sclk_i),
        .fall_o (fall)
    );

    sso_frame #(
        .PORT_W (PORT_W),
        .CNT_W  (CNT_W),
        .UL_W   (UL_W),
        .PAD_W  (PAD_W)
    ) u_frame (
        .port_i   (port_i),
        .count_i  (count_i),
        .unlock_i (unlock_i),
        .frame_o  (frame)
    );

    sso_shifter #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sel_i   (sel),
        .fall_i  (fall),
        .frame_i (frame),
        .sdo_o   (sdo_o),
        .clr_o   (unlock_clr_o)
    );
endmodule

// File: rtl/sso_checker.sv
module sso_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic sclk_i,
    input logic sen_i,
    input logic rd_mode_i,
    input logic port0_i,
    input logic sdo_o,
    input logic unlock_clr_o
);
    logic sel;
    assign sel = sen_i & rd_mode_i;

    AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sel |=> !sdo_o); // R5

    AST_CLR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        unlock_clr_o |=> !unlock_clr_o); // R6

    AST_CLR_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel && !$past(sel)) |=> unlock_clr_o); // R6

    AST_FIRST_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel && !$past(sel)) |=> (sdo_o == $past(port0_i))); // R3

    AST_HOLD_NO_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel && $past(sel) && !($past(sclk_i) && !sclk_i)) |=> $stable(sdo_o)); // R4
endmodule

bind status_shift_out sso_checker u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sclk_i       (sclk_i),
    .sen_i        (sen_i),
    .rd_mode_i    (rd_mode_i),
    .port0_i      (port_i[0]),
    .sdo_o        (sdo_o),
    .unlock_clr_o (unlock_clr_o)
);

// File: tb/status_shift_out_bench.sv
module status_shift_out_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NBITS      = 28;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        sclk = 1'b0;
    logic        sen = 1'b0;
    logic        rd_mode = 1'b0;
    logic [1:0]  port = '0;
    logic [19:0] count = '0;
    logic [3:0]  unlock = '0;
    logic        sdo;
    logic        clr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    status_shift_out u_status_shift_out (
        .clk_i        (clk),
        .rst_ni       (rst_ni),
        .sclk_i       (sclk),
        .sen_i        (sen),
        .rd_mode_i    (rd_mode),
        .port_i       (port),
        .count_i      (count),
        .unlock_i     (unlock),
        .sdo_o        (sdo),
        .unlock_clr_o (clr)
    );

    function automatic logic exp_bit(logic [1:0] p, logic [19:0] c, logic [3:0] u, int k);
        if (k < 2)       return p[k];
        else if (k < 22) return c[21-k];
        else if (k < 26) return u[25-k];
        else             return 1'b0;
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic read_session(logic [1:0] p, logic [19:0] c, logic [3:0] u,
                                bit scramble, int extra);
        string tag;
        tag = scramble ? "R2" : "R3";
        port = p; count = c; unlock = u;
        sen = 1'b1; rd_mode = 1'b1;
        tick();
        chk("R3 R8 first bit", sdo, exp_bit(p, c, u, 0));
        chk("R6 clear pulse", clr, 1'b1);
        if (scramble) begin
            port = ~p; count = ~c; unlock = ~u;
        end
        tick();
        chk("R6 clear single", clr, 1'b0);
        chk("R4 hold without edge", sdo, exp_bit(p, c, u, 0));
        for (int k = 1; k < NBITS + extra; k++) begin
            sclk = 1'b1;
            tick();
            chk("R4 stable on rise", sdo, exp_bit(p, c, u, k-1));
            sclk = 1'b0;
            tick();
            if (k >= NBITS) chk("R7 zero fill", sdo, 1'b0);
            else            chk(tag, sdo, exp_bit(p, c, u, k));
        end
        sen = 1'b0;
        tick();
        chk("R5 low after enable drop", sdo, 1'b0);
        rd_mode = 1'b0;
        tick();
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) tick();
        chk("R1 sdo reset", sdo, 1'b0);
        chk("R1 clr reset", clr, 1'b0);
        rst_ni = 1'b1;
        tick();
        chk("R1 sdo idle", sdo, 1'b0);
        chk("R1 clr idle", clr, 1'b0);

        read_session(2'b11, 20'hFFFFF, 4'hF, 1'b0, 2);
        read_session(2'b01, 20'hAAAAA, 4'h5, 1'b0, 0);
        read_session(2'b10, 20'h55555, 4'hA, 1'b1, 0);
        read_session(2'b00, 20'h00000, 4'h0, 1'b0, 1);

        // enable high, read mode low: no capture, no output
        sen = 1'b1; rd_mode = 1'b0; port = 2'b11; count = '1; unlock = '1;
        for (int i = 0; i < 4; i++) begin
            sclk = 1'b1; tick();
            sclk = 1'b0; tick();
            chk("R5 mode low output", sdo, 1'b0);
            chk("R6 no clear without entry", clr, 1'b0);
        end
        sen = 1'b0;
        tick();

        for (int n = 0; n < 24; n++) begin
            read_session(2'($urandom()), 20'($urandom()), 4'($urandom()),
                         bit'($urandom() % 2), int'($urandom() % 3));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule